// File: doc/BRIEF.md
# Byte Subtract-With-Borrow Execute Unit

This block is the execute stage of one instruction of an 8-bit accumulator machine: the subtract of a file register and the borrow from the working register W. The instruction word is held steady for four clock cycles. A two-bit phase input steps through those cycles in order: decode, operand read, compute and write-back. In the decode phase the unit recognises the opcode and forms a 12-bit register-file address. It can take that address from a fixed access window or from a bank-select value. In the read phase it captures the file operand, W and the carry flag. In the compute phase it forms W minus the operand minus the borrow, where the borrow is the inverted carry, and produces five status flags. In the write phase it raises exactly one data write enable, for W or for the file register, together with the status write enable.

The register file, W and the status register are held outside the unit. The register file has a combinational read port and is written on the clock edge at the end of the write phase when `rf_we_o` is high. The reset input is asynchronous and active low. Its release is synchronised inside the unit, which takes two clock edges.

Top module: `subb_exec_unit`

## Requirements
- R1: Only an instruction whose bits [15:10] equal 6'b010101 leads to any write enable in the write phase. Any other word leaves `rf_we_o`, `w_we_o` and `status_we_o` low.
- R2: When bit 8 of the instruction is 0, the address is {4'h0, f} for an f (bits [7:0]) below 8'h60, and {4'hF, f} for any other f. The address is presented on `rf_addr_o` from the read phase onward.
- R3: When bit 8 is 1, the address is {bsr_i, f}.
- R4: The result is (W − f − (1 − C)) modulo 256. W and C are sampled in the read phase, together with the file operand.
- R5: Bit 9 selects the destination. A value of 0 raises `w_we_o` with the result on `w_o`. A value of 1 raises `rf_we_o` with the result on `rf_wdata_o`. The two are never high together.
- R6: Status bit 0 (C) is 1 exactly when W ≥ f + (1 − C_in), that is, when the subtraction needs no borrow.
- R7: Status bit 1 (DC) is 1 exactly when W[3:0] ≥ f[3:0] + (1 − C_in).
- R8: Status bit 2 (Z) is 1 when the result is zero. Status bit 4 (N) equals bit 7 of the result.
- R9: Status bit 3 (OV) is 1 when the signed difference W − f − (1 − C_in) lies outside −128..127.
- R10: Write enables are high only while the phase input is 3 (write). They stay low in phases 0 (decode), 1 (read) and 2 (compute).
- R11: While reset is asserted, all write enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_i | input | 2 | Cycle phase: 0 decode, 1 read, 2 compute, 3 write |
| instr_i | input | 16 | Instruction word, held steady across all four phases |
| w_i | input | 8 | Current W value |
| bsr_i | input | 4 | Bank-select value |
| c_i | input | 1 | Current carry flag |
| rf_rdata_i | input | 8 | Register-file read data for `rf_addr_o` |
| rf_addr_o | output | 12 | Register-file address |
| rf_wdata_o | output | 8 | Register-file write data |
| rf_we_o | output | 1 | Register-file write enable |
| w_o | output | 8 | New W value |
| w_we_o | output | 1 | W write enable |
| status_o | output | 5 | New flags: bit0 C, bit1 DC, bit2 Z, bit3 OV, bit4 N |
| status_we_o | output | 1 | Status write enable |

## Verification
Directed vectors cover these corner cases:
- A negative result with a borrow out.
- A positive result with no borrow.
- A zero result produced only by the incoming borrow.
- File addresses on either side of the 8'h60 access boundary.

A unit that ignored the incoming carry would get the zero case wrong. A unit that took W as the subtrahend would give the wrong sign and the wrong C in the negative case. An off-by-one access split would misaddress 8'h5F or 8'h60.

Random vectors with a fixed seed mix near-miss opcodes and both bank and destination bits. They expose a DC flag taken from the wrong nibble and an OV flag computed as for addition. Write enables are sampled in every phase to catch early or doubled writes.

// File: rtl/subb_pkg.sv
package subb_pkg;
  typedef enum logic [1:0] {
    PH_DECODE = 2'd0,
    PH_READ   = 2'd1,
    PH_CALC   = 2'd2,
    PH_WRITE  = 2'd3
  } phase_e;

  localparam int FLG_C  = 0;
  localparam int FLG_DC = 1;
  localparam int FLG_Z  = 2;
  localparam int FLG_OV = 3;
  localparam int FLG_N  = 4;
  localparam int FLG_W  = 5;

  localparam int        OPC_W    = 6;
  localparam logic [5:0] OPC_SUBB = 6'b010101;
endpackage

// File: rtl/subb_decode.sv
module subb_decode
  import subb_pkg::*;
#(
  parameter int               INSTR_W = 16,
  parameter int               FADDR_W = 8,
  parameter int               BSR_W   = 4,
  parameter logic [FADDR_W-1:0] ACC_SPLIT = 8'h60,
  parameter logic [BSR_W-1:0]   SFR_BANK  = 4'hF,
  localparam int              ADDR_W  = BSR_W + FADDR_W
) (
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [BSR_W-1:0]   bsr_i,
  output logic               hit_o,
  output logic               dst_file_o,
  output logic               bank_sel_o,
  output logic [ADDR_W-1:0]  addr_o
);
  localparam int D_BIT = FADDR_W + 1;
  localparam int A_BIT = FADDR_W;

  logic [FADDR_W-1:0] f_field;
  logic [BSR_W-1:0]   acc_bank;

  assign f_field    = instr_i[FADDR_W-1:0];
  assign hit_o      = (instr_i[INSTR_W-1 -: OPC_W] == OPC_SUBB);
  assign dst_file_o = instr_i[D_BIT];
  assign bank_sel_o = instr_i[A_BIT];

  always_comb begin
    if (f_field < ACC_SPLIT) acc_bank = '0;
    else                     acc_bank = SFR_BANK;
  end

  always_comb begin
    if (bank_sel_o) addr_o = {bsr_i, f_field};
    else            addr_o = {acc_bank, f_field};
  end
endmodule

// File: rtl/subb_alu.sv
module subb_alu
  import subb_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int HALF_W = DATA_W / 2
) (
  input  logic [DATA_W-1:0] minu_i,
  input  logic [DATA_W-1:0] subt_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] res_o,
  output logic [FLG_W-1:0]  flags_o
);
  logic             borrow_in;
  logic [DATA_W:0]  full_diff;
  logic [HALF_W:0]  low_diff;

  assign borrow_in = ~carry_i;

  always_comb begin
    full_diff = {1'b0, minu_i} - {1'b0, subt_i} - {{DATA_W{1'b0}}, borrow_in};
    low_diff  = {1'b0, minu_i[HALF_W-1:0]} - {1'b0, subt_i[HALF_W-1:0]}
              - {{HALF_W{1'b0}}, borrow_in};
    res_o     = full_diff[DATA_W-1:0];

    flags_o          = '0;
    flags_o[FLG_C]   = ~full_diff[DATA_W];
    flags_o[FLG_DC]  = ~low_diff[HALF_W];
    flags_o[FLG_Z]   = (full_diff[DATA_W-1:0] == '0);
    flags_o[FLG_N]   = full_diff[DATA_W-1];
    flags_o[FLG_OV]  = (minu_i[DATA_W-1] ^ subt_i[DATA_W-1])
                     & (minu_i[DATA_W-1] ^ full_diff[DATA_W-1]);
  end
endmodule

// File: rtl/subb_rst_sync.sv
module subb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/subb_exec_unit.sv
module subb_exec_unit
  import subb_pkg::*;
#(
  parameter int               DATA_W    = 8,
  parameter int               FADDR_W   = 8,
  parameter int               BSR_W     = 4,
  parameter int               INSTR_W   = 16,
  parameter logic [FADDR_W-1:0] ACC_SPLIT = 8'h60,
  parameter logic [BSR_W-1:0]   SFR_BANK  = 4'hF,
  localparam int              ADDR_W    = BSR_W + FADDR_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         phase_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [DATA_W-1:0]  w_i,
  input  logic [BSR_W-1:0]   bsr_i,
  input  logic               c_i,
  input  logic [DATA_W-1:0]  rf_rdata_i,
  output logic [ADDR_W-1:0]  rf_addr_o,
  output logic [DATA_W-1:0]  rf_wdata_o,
  output logic               rf_we_o,
  output logic [DATA_W-1:0]  w_o,
  output logic               w_we_o,
  output logic [FLG_W-1:0]   status_o,
  output logic               status_we_o
);
  logic rst_sync_n;

  subb_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // phase strobes, used as clock enables
  logic en_dec, en_rd, en_calc, in_wr;
  assign en_dec  = (phase_i == PH_DECODE);
  assign en_rd   = (phase_i == PH_READ);
  assign en_calc = (phase_i == PH_CALC);
  assign in_wr   = (phase_i == PH_WRITE);

  // decode stage
  logic              dec_hit, dec_dst, dec_bank;
  logic [ADDR_W-1:0] dec_addr;

  subb_decode #(
    .INSTR_W   (INSTR_W),
    .FADDR_W   (FADDR_W),
    .BSR_W     (BSR_W),
    .ACC_SPLIT (ACC_SPLIT),
    .SFR_BANK  (SFR_BANK)
  ) decode_i (
    .instr_i    (instr_i),
    .bsr_i      (bsr_i),
    .hit_o      (dec_hit),
    .dst_file_o (dec_dst),
    .bank_sel_o (dec_bank),
    .addr_o     (dec_addr)
  );

  logic              hit_q, hit_d;
  logic              dst_q, dst_d;
  logic              bank_q, bank_d;
  logic [ADDR_W-1:0] addr_q, addr_d;

  always_comb begin
    hit_d  = hit_q;
    dst_d  = dst_q;
    bank_d = bank_q;
    addr_d = addr_q;
    if (en_dec) begin
      hit_d  = dec_hit;
      dst_d  = dec_dst;
      bank_d = dec_bank;
      addr_d = dec_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      hit_q  <= 1'b0;
      dst_q  <= 1'b0;
      bank_q <= 1'b0;
      addr_q <= '0;
    end else begin
      hit_q  <= hit_d;
      dst_q  <= dst_d;
      bank_q <= bank_d;
      addr_q <= addr_d;
    end
  end

  // operand read stage
  logic [DATA_W-1:0] opw_q, opw_d, opf_q, opf_d;
  logic              cin_q, cin_d;

  always_comb begin
    opw_d = opw_q;
    opf_d = opf_q;
    cin_d = cin_q;
    if (en_rd) begin
      opw_d = w_i;
      opf_d = rf_rdata_i;
      cin_d = c_i;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      opw_q <= '0;
      opf_q <= '0;
      cin_q <= 1'b0;
    end else begin
      opw_q <= opw_d;
      opf_q <= opf_d;
      cin_q <= cin_d;
    end
  end

  // compute stage
  logic [DATA_W-1:0] alu_res;
  logic [FLG_W-1:0]  alu_flags;

  subb_alu #(.DATA_W(DATA_W)) alu_i (
    .minu_i  (opw_q),
    .subt_i  (opf_q),
    .carry_i (cin_q),
    .res_o   (alu_res),
    .flags_o (alu_flags)
  );

  logic [DATA_W-1:0] res_q, res_d;
  logic [FLG_W-1:0]  flg_q, flg_d;

  always_comb begin
    res_d = res_q;
    flg_d = flg_q;
    if (en_calc) begin
      res_d = alu_res;
      flg_d = alu_flags;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_q <= '0;
      flg_q <= '0;
    end else begin
      res_q <= res_d;
      flg_q <= flg_d;
    end
  end

  // write-back stage
  assign rf_addr_o   = addr_q;
  assign rf_wdata_o  = res_q;
  assign w_o         = res_q;
  assign status_o    = flg_q;
  assign rf_we_o     = in_wr & hit_q & dst_q;
  assign w_we_o      = in_wr & hit_q & ~dst_q;
  assign status_we_o = in_wr & hit_q;

  // R10
  wr_phase_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rf_we_o || w_we_o || status_we_o) |-> (phase_i == PH_WRITE));

  // R5
  wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    status_we_o |-> $countones({rf_we_o, w_we_o}) == 1);

  // R6
  carry_flag_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    status_we_o |-> status_o[FLG_C] ==
      ({1'b0, opw_q} >= ({1'b0, opf_q} + {{DATA_W{1'b0}}, ~cin_q})));

  // R8
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    status_we_o |-> status_o[FLG_Z] == (rf_wdata_o == '0));

  // R2
  access_map_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (en_rd && hit_q && !bank_q) |->
      rf_addr_o[ADDR_W-1:FADDR_W] ==
        ((rf_addr_o[FADDR_W-1:0] >= ACC_SPLIT) ? SFR_BANK : '0));

  // R11
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_sync_n |-> !(rf_we_o || w_we_o || status_we_o));
endmodule

// File: tb/subb_exec_unit_tb_top.sv
`timescale 1ns/1ps
module subb_exec_unit_tb_top;
  logic        clk;
  logic        rst_n;
  logic [1:0]  phase_i;
  logic [15:0] instr_i;
  logic [7:0]  w_i;
  logic [3:0]  bsr_i;
  logic        c_i;
  logic [7:0]  rf_rdata_i;
  logic [11:0] rf_addr_o;
  logic [7:0]  rf_wdata_o;
  logic        rf_we_o;
  logic [7:0]  w_o;
  logic        w_we_o;
  logic [4:0]  status_o;
  logic        status_we_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] salt = 8'h00;

  subb_exec_unit dut_i (
    .clk(clk), .rst_n(rst_n), .phase_i(phase_i), .instr_i(instr_i),
    .w_i(w_i), .bsr_i(bsr_i), .c_i(c_i), .rf_rdata_i(rf_rdata_i),
    .rf_addr_o(rf_addr_o), .rf_wdata_o(rf_wdata_o), .rf_we_o(rf_we_o),
    .w_o(w_o), .w_we_o(w_we_o), .status_o(status_o), .status_we_o(status_we_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [7:0] mem_hash(input logic [11:0] a);
    return a[7:0] ^ {a[11:8], a[3:0]} ^ 8'h5A;
  endfunction

  always_comb rf_rdata_i = mem_hash(rf_addr_o) ^ salt;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] exp_addr(input logic [15:0] ins, input logic [3:0] b);
    if (ins[8]) return {b, ins[7:0]};
    if (ins[7:0] < 8'h60) return {4'h0, ins[7:0]};
    return {4'hF, ins[7:0]};
  endfunction

  // returns {N, OV, Z, DC, C, result}
  function automatic logic [12:0] model(input int w, input int f, input int c);
    int brw, d, dl, sw, sf, sd;
    logic [7:0] r;
    brw = 1 - c;
    d   = w - f - brw;
    dl  = (w % 16) - (f % 16) - brw;
    sw  = (w >= 128) ? w - 256 : w;
    sf  = (f >= 128) ? f - 256 : f;
    sd  = sw - sf - brw;
    r   = 8'(d);
    return {r[7], (sd > 127 || sd < -128), (r == 8'h00), (dl >= 0), (d >= 0), r};
  endfunction

  task automatic run_vec(input logic [15:0] ins, input logic [7:0] w,
                         input logic [3:0] b, input logic c, input logic [7:0] fval);
    logic [11:0] ea;
    logic [12:0] m;
    logic        hit;
    ea   = exp_addr(ins, b);
    m    = model(int'(w), int'(fval), int'(c));
    hit  = (ins[15:10] == 6'b010101);
    for (int ph = 0; ph < 4; ph++) begin
      @(negedge clk);
      if (ph == 0) begin
        instr_i = ins; w_i = w; bsr_i = b; c_i = c;
        salt    = fval ^ mem_hash(ea);
      end
      phase_i = 2'(ph);
      #1;
      if (ph == 1 && hit) check(ins[8] ? "R3 bank addr" : "R2 access addr",
                                int'(rf_addr_o), int'(ea));
      if (ph != 3) check("R10 early write", int'({rf_we_o, w_we_o, status_we_o}), 0);
      if (ph == 3) begin
        if (!hit) begin
          check("R1 miss writes", int'({rf_we_o, w_we_o, status_we_o}), 0);
        end else begin
          check("R5 dest enables", int'({rf_we_o, w_we_o, status_we_o}),
                int'({ins[9], ~ins[9], 1'b1}));
          check("R4 result", int'(ins[9] ? rf_wdata_o : w_o), int'(m[7:0]));
          check("R6 C flag",  int'(status_o[0]), int'(m[8]));
          check("R7 DC flag", int'(status_o[1]), int'(m[9]));
          check("R8 Z/N flags", int'({status_o[4], status_o[2]}), int'({m[12], m[10]}));
          check("R9 OV flag", int'(status_o[3]), int'(m[11]));
        end
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'd1234);
    rst_n = 1'b0; phase_i = 2'd3; instr_i = 16'h5400; w_i = '0; bsr_i = '0; c_i = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check("R11 reset writes", int'({rf_we_o, w_we_o, status_we_o}), 0);
    @(negedge clk); rst_n = 1'b1; phase_i = 2'd0;
    repeat (3) @(negedge clk);

    // directed cases
    run_vec(16'h5700 | 16'h0010, 8'd2, 4'h0, 1'b1, 8'd3);  // negative, file dest
    run_vec(16'h5400 | 16'h0020, 8'd5, 4'h0, 1'b1, 8'd2);  // positive, W dest
    run_vec(16'h5700 | 16'h0030, 8'd2, 4'h0, 1'b0, 8'd1);  // zero via borrow
    run_vec(16'h545F, 8'h80, 4'h3, 1'b1, 8'h01);           // R2 boundary below, OV
    run_vec(16'h5460, 8'h7F, 4'h3, 1'b0, 8'hFF);           // R2 boundary at split
    run_vec(16'h55A0, 8'h10, 4'h9, 1'b1, 8'h01);           // R3 bank select
    run_vec(16'h5800, 8'h10, 4'h9, 1'b1, 8'h01);           // R1 other opcode
    run_vec(16'h5000, 8'h10, 4'h9, 1'b1, 8'h01);           // R1 near-miss

    for (int i = 0; i < 300; i++) begin
      logic [15:0] ins;
      ins = 16'($urandom);
      if ($urandom_range(3) != 0) ins[15:10] = 6'b010101;
      run_vec(ins, 8'($urandom), 4'($urandom), 1'($urandom), 8'($urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule